// File: doc/BRIEF.md
# Multi-mode 16-bit Waveform Timer

This block is a 16-bit up/down counter that advances by one step on each cycle where a clock-enable `tick` is high. Around it sit a period register and four compare channels. Each has two copies: a buffer that the write port fills, and an active copy that the counting logic uses. Each buffer is copied to its active copy only at the update point of the current mode, so a period or compare change never takes effect part way through a cycle of the waveform.

Three counting modes are supported. In normal mode the counter runs up to the active period and wraps to zero. In frequency mode the active compare value of channel 0 sets the top of the count, the period is unused, and every channel output toggles on its match. In dual-slope mode the counter climbs to the period and then descends to zero. A channel output is cleared on a match while the counter climbs and set on a match while it descends, which gives centre-aligned PWM. The wrap or bottom event is reported as a one-cycle `ovf_o` pulse, and each channel reports its match as a one-cycle `cmp_hit_o` pulse.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset the count is 0, `dir_down_o` is 1, all waves and flags are 0, the active and buffered period are 0xFFFF, and all compare values are 0.
- R2: On a cycle without `tick` and without a counter write, the count, direction and waves keep their values, and `ovf_o` and `cmp_hit_o` are 0 on the next cycle.
- R3: In normal mode (`mode`=0, and also `mode`=3), a tick with count equal to the active period, or equal to 0xFFFF, returns the count to 0. `ovf_o` is high for exactly the cycle in which the count shows that 0. Any other tick adds one to the count.
- R4: Write addresses are 1 for the period buffer and 2+k for the compare buffer of channel k. A written value only reaches the active copy on the update tick: the wrap in single-slope modes, or the bottom of dual-slope mode. If a write lands on the update tick, the active copy takes the earlier buffer content.
- R5: `cmp_hit_o[k]` is high for one cycle after any tick on which the count equals the active compare value of channel k. This holds in every mode.
- R6: In frequency mode (`mode`=1), the active compare value of channel 0 replaces the period as the top of the count, and the period value has no effect on the count.
- R7: In frequency mode, each `wave_o[k]` inverts on every match of channel k. With channel 0 at 0 the count stays at 0 and `wave_o[0]` inverts on every tick.
- R8: In dual-slope mode (`mode`=2, legal period 3 to 0xFFFF), the count rises one per tick to the period and then falls to 0. `dir_down_o` is 1 while falling. The tick at the bottom moves the count to 1, pulses `ovf_o` and performs the buffer update. The first tick after reset is a bottom tick.
- R9: In dual-slope mode, a match while rising drives `wave_o[k]` to 0, and a match while falling (including the bottom) drives it to 1.
- R10: A write to address 0 loads the count on that clock edge whatever `tick` is. That cycle has no count step, no flag, no wave change and no buffer update.
- R11: In normal mode the wave outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| mode | input | 2 | 0 normal, 1 frequency, 2 dual-slope, 3 as normal |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | 0 count, 1 period buffer, 2..5 compare buffers of channels 0..3 |
| wr_data | input | 16 | Write value |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | Counting direction, 1 while descending |
| ovf_o | output | 1 | One-cycle wrap / bottom pulse |
| cmp_hit_o | output | 4 | One-cycle match pulse per channel |
| wave_o | output | 4 | Waveform output per channel |

## Verification
On every cycle the assertions check that idle cycles freeze the count and the waves, that a counter write wins over the tick, that the dual-slope count moves by exactly one per tick, and that the wave edges follow the match pulses in frequency and dual-slope modes. They also check that the active period only changes on update ticks and that the wrap pulse follows a top value. Only the bench scenarios can show the full timing of the double buffering: a period that stays inactive while the count runs past it, a wider dual-slope period that takes effect only at the next bottom, and the complete toggle and duty sequences. The bench checks these against its own phase-based model of the count, cycle by cycle.

// File: rtl/tmr_wavegen_pkg.sv
package tmr_wavegen_pkg;

  localparam int unsigned TMR_CW = 16;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_FREQ   = 2'b01,
    MODE_DUAL   = 2'b10,
    MODE_RSVD   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic [TMR_CW-1:0] nxt;
    logic              dir_down;
    logic              evt;
  } tmr_step_t;

  // One counting step: next value, next direction, and whether this step
  // is the update point (wrap or dual-slope bottom).
  function automatic tmr_step_t tmr_step(
    input tmr_mode_e         m,
    input logic [TMR_CW-1:0] c,
    input logic              dn,
    input logic [TMR_CW-1:0] per,
    input logic [TMR_CW-1:0] cmpa
  );
    tmr_step_t         r;
    logic [TMR_CW-1:0] top;
    r.nxt      = c;
    r.dir_down = dn;
    r.evt      = 1'b0;
    top        = (m == MODE_FREQ) ? cmpa : per;
    if (m == MODE_DUAL) begin
      if (dn) begin
        if (c == '0) begin
          r.nxt      = TMR_CW'(1);
          r.dir_down = 1'b0;
          r.evt      = 1'b1;
        end else begin
          r.nxt = c - TMR_CW'(1);
        end
      end else begin
        if (c >= per) begin
          r.nxt      = per - TMR_CW'(1);
          r.dir_down = 1'b1;
        end else begin
          r.nxt = c + TMR_CW'(1);
        end
      end
    end else begin
      if (c == top || c == '1) begin
        r.nxt = '0;
        r.evt = 1'b1;
      end else begin
        r.nxt = c + TMR_CW'(1);
      end
    end
    return r;
  endfunction

  // New wave level on a compare match.
  function automatic logic wave_next(
    input tmr_mode_e m,
    input logic      cur,
    input logic      dn
  );
    logic r;
    case (m)
      MODE_FREQ: r = ~cur;
      MODE_DUAL: r = dn;
      default:   r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_wavegen_shadow.sv
module tmr_wavegen_shadow #(
  parameter int unsigned    W       = 16,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         upd_i,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o
);

  logic [W-1:0] buf_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= RST_VAL;
      act_q <= RST_VAL;
    end else begin
      if (upd_i) act_q <= buf_q;
      if (wr_i)  buf_q <= wdata_i;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;

endmodule

// File: rtl/tmr_wavegen_cnt.sv
module tmr_wavegen_cnt
  import tmr_wavegen_pkg::*;
#(
  parameter int unsigned CW = TMR_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_cnt_i,
  input  logic [CW-1:0] wr_data_i,
  input  tmr_mode_e     mode_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] top_a_i,
  output logic [CW-1:0] cnt_o,
  output logic          dir_down_o,
  output logic          adv_o,
  output logic          upd_o,
  output logic          ovf_o
);

  logic [CW-1:0] cnt_q;
  logic          dn_q;
  logic          ovf_q;
  tmr_step_t     st;

  always_comb st = tmr_step(mode_i, cnt_q, dn_q, per_i, top_a_i);

  assign adv_o = tick_i && !wr_cnt_i;
  assign upd_o = adv_o && st.evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= upd_o;
      if (wr_cnt_i) begin
        cnt_q <= wr_data_i;
      end else if (adv_o) begin
        cnt_q <= st.nxt;
        dn_q  <= st.dir_down;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dn_q;
  assign ovf_o      = ovf_q;

endmodule

// File: rtl/tmr_wavegen_chan.sv
module tmr_wavegen_chan
  import tmr_wavegen_pkg::*;
#(
  parameter int unsigned CW = TMR_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dir_down_i,
  input  tmr_mode_e     mode_i,
  input  logic [CW-1:0] cmp_i,
  output logic          hit_o,
  output logic          wave_o
);

  logic match;
  logic hit_q;
  logic wave_q;

  assign match = adv_i && (cnt_i == cmp_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      hit_q <= match;
      if (match) wave_q <= wave_next(mode_i, wave_q, dir_down_i);
    end
  end

  assign hit_o  = hit_q;
  assign wave_o = wave_q;

endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
  import tmr_wavegen_pkg::*;
#(
  parameter int unsigned CNT_W  = TMR_CW,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = $clog2(NUM_CH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_down_o,
  output logic              ovf_o,
  output logic [NUM_CH-1:0] cmp_hit_o,
  output logic [NUM_CH-1:0] wave_o
);

  localparam logic [ADDR_W-1:0] ADDR_CNT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PER = ADDR_W'(1);
  localparam int unsigned       CH_BASE  = 2;

  tmr_mode_e       mode_e;
  logic            cnt_wr_w;
  logic            per_wr_w;
  logic            adv_w;
  logic            upd_w;
  logic [CNT_W-1:0] per_buf_w;
  logic [CNT_W-1:0] per_act_w;
  logic [CNT_W-1:0] cmp_buf_w [NUM_CH];
  logic [CNT_W-1:0] cmp_act_w [NUM_CH];
  logic [CNT_W-1:0] cmpa_act_w;

  assign mode_e     = tmr_mode_e'(mode);
  assign cnt_wr_w   = wr_en && (wr_addr == ADDR_CNT);
  assign per_wr_w   = wr_en && (wr_addr == ADDR_PER);
  assign cmpa_act_w = cmp_act_w[0];

  tmr_wavegen_shadow #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (per_wr_w),
    .wdata_i (wr_data),
    .upd_i   (upd_w),
    .buf_o   (per_buf_w),
    .act_o   (per_act_w)
  );

  tmr_wavegen_cnt #(.CW(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .wr_cnt_i   (cnt_wr_w),
    .wr_data_i  (wr_data),
    .mode_i     (mode_e),
    .per_i      (per_act_w),
    .top_a_i    (cmpa_act_w),
    .cnt_o      (count_o),
    .dir_down_o (dir_down_o),
    .adv_o      (adv_w),
    .upd_o      (upd_w),
    .ovf_o      (ovf_o)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && (wr_addr == ADDR_W'(CH_BASE + k));

    tmr_wavegen_shadow #(.W(CNT_W), .RST_VAL('0)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ch_wr),
      .wdata_i (wr_data),
      .upd_i   (upd_w),
      .buf_o   (cmp_buf_w[k]),
      .act_o   (cmp_act_w[k])
    );

    tmr_wavegen_chan #(.CW(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (adv_w),
      .cnt_i      (count_o),
      .dir_down_i (dir_down_o),
      .mode_i     (mode_e),
      .cmp_i      (cmp_act_w[k]),
      .hit_o      (cmp_hit_o[k]),
      .wave_o     (wave_o[k])
    );
  end

endmodule

// File: rtl/tmr_wavegen_chk.sv
module tmr_wavegen_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [1:0]        mode,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  count_o,
  input logic              dir_down_o,
  input logic              ovf_o,
  input logic [NUM_CH-1:0] cmp_hit_o,
  input logic [NUM_CH-1:0] wave_o,
  input logic              upd_w,
  input logic [CNT_W-1:0]  per_act_w,
  input logic [CNT_W-1:0]  cmpa_act_w
);

  logic cwr;
  assign cwr = wr_en && (wr_addr == '0);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tick && !cwr) |-> ($stable(count_o) && $stable(wave_o) &&
                              $stable(dir_down_o) && !ovf_o && cmp_hit_o == '0));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && $past(mode) != 2'b10) |-> count_o == '0);

  p_upd_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_w |=> $stable(per_act_w));

  p_freq_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && $past(mode) == 2'b01) |->
      ($past(count_o) == $past(cmpa_act_w) || $past(count_o) == '1));

  p_freq_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b01 && $past(rst_n)) |->
      ((wave_o[0] != $past(wave_o[0])) == cmp_hit_o[0]));

  p_dual_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick && !cwr && mode == 2'b10) && $past(rst_n)) |->
      (count_o == $past(count_o) + CNT_W'(1) || count_o == $past(count_o) - CNT_W'(1)));

  p_dual_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && $past(mode) == 2'b10) |-> (count_o == CNT_W'(1) && !dir_down_o));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_a
    p_dual_wave_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit_o[k] && $past(mode) == 2'b10) |-> wave_o[k] == $past(dir_down_o));

    p_normal_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b00 && $past(rst_n)) |-> $stable(wave_o[k]));
  end

  p_cnt_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cwr) && $past(rst_n)) |->
      (count_o == $past(wr_data) && !ovf_o && cmp_hit_o == '0 && $stable(wave_o)));

endmodule

bind tmr_wavegen tmr_wavegen_chk #(
  .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .mode       (mode),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .count_o    (count_o),
  .dir_down_o (dir_down_o),
  .ovf_o      (ovf_o),
  .cmp_hit_o  (cmp_hit_o),
  .wave_o     (wave_o),
  .upd_w      (upd_w),
  .per_act_w  (per_act_w),
  .cmpa_act_w (cmpa_act_w)
);

// File: tb/tmr_wavegen_tb_top.sv
`timescale 1ns/1ps
module tmr_wavegen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        dir_down_o;
  logic        ovf_o;
  logic [3:0]  cmp_hit_o;
  logic [3:0]  wave_o;

  always #2.5 clk = ~clk;

  tmr_wavegen dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .dir_down_o(dir_down_o), .ovf_o(ovf_o),
    .cmp_hit_o(cmp_hit_o), .wave_o(wave_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    int       due;
    int       cnt;
    bit       dn;
    bit       ovf;
    bit [3:0] hit;
    bit [3:0] wave;
    string    tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state
  int       m_cnt, m_ph, m_per_b, m_per_a;
  int       m_cb[4];
  int       m_ca[4];
  bit [3:0] m_wave;
  bit       m_dn;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int dual_cnt(int ph, int per);
    return (ph <= per) ? ph : 2 * per - ph;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_ph = 0; m_per_b = 65535; m_per_a = 65535;
    for (int k = 0; k < 4; k++) begin m_cb[k] = 0; m_ca[k] = 0; end
    m_wave = '0; m_dn = 1'b1;
  endtask

  task automatic model_load();
    m_per_a = m_per_b;
    for (int k = 0; k < 4; k++) m_ca[k] = m_cb[k];
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(bit tk, bit we, int addr, int data, string tag);
    exp_t     e;
    bit       ovf;
    bit [3:0] hit;
    int       c;
    bit       dn_now;
    @(negedge clk);
    tick = tk; wr_en = we; wr_addr = 3'(addr); wr_data = 16'(data);
    ovf = 0; hit = '0;
    if (we && addr == 0) begin
      m_cnt = data & 16'hFFFF;
    end else if (tk) begin
      if (mode == 2'b10) begin
        c = dual_cnt(m_ph, m_per_a);
        dn_now = (m_ph == 0) || (m_ph > m_per_a);
      end else begin
        c = m_cnt;
        dn_now = m_dn;
      end
      for (int k = 0; k < 4; k++) begin
        if (c == m_ca[k]) begin
          hit[k] = 1'b1;
          if (mode == 2'b01) m_wave[k] = ~m_wave[k];
          else if (mode == 2'b10) m_wave[k] = dn_now;
        end
      end
      if (mode == 2'b10) begin
        if (m_ph == 0) begin
          ovf = 1; model_load(); m_ph = 1;
        end else begin
          m_ph = m_ph + 1;
          if (m_ph == 2 * m_per_a) m_ph = 0;
        end
        m_dn = (m_ph == 0) || (m_ph > m_per_a);
      end else begin
        if (c == ((mode == 2'b01) ? m_ca[0] : m_per_a) || c == 65535) begin
          m_cnt = 0; ovf = 1; model_load();
        end else begin
          m_cnt = c + 1;
        end
      end
    end
    if (we && addr == 1) m_per_b = data & 16'hFFFF;
    if (we && addr >= 2 && addr <= 5) m_cb[addr-2] = data & 16'hFFFF;
    e.due  = cyc + 1;
    e.cnt  = (mode == 2'b10) ? dual_cnt(m_ph, m_per_a) : m_cnt;
    e.dn   = m_dn;
    e.ovf  = ovf;
    e.hit  = hit;
    e.wave = m_wave;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations once they are due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "count", int'(count_o), e.cnt);
      chk(e.tag, "dir", int'(dir_down_o), int'(e.dn));
      chk(e.tag, "ovf", int'(ovf_o), int'(e.ovf));
      chk(e.tag, "hit", int'(cmp_hit_o), int'(e.hit));
      chk(e.tag, "wave", int'(wave_o), int'(e.wave));
    end
  end

  task automatic reset_dut(logic [1:0] m);
    @(negedge clk);
    tick = 0; wr_en = 0;
    @(negedge clk);
    rst_n = 0; mode = m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    // R1: reset state seen at the ports
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "dir", int'(dir_down_o), 1);
    chk("R1", "ovf", int'(ovf_o), 0);
    chk("R1", "hit", int'(cmp_hit_o), 0);
    chk("R1", "wave", int'(wave_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    // normal mode
    reset_dut(2'b00);
    drive(1, 1, 1, 5, "R4");
    drive(0, 1, 3, 2, "R5");
    for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, "R4");
    drive(1, 1, 0, 16'hFFFE, "R10");
    drive(1, 0, 0, 0, "R3");
    drive(1, 0, 0, 0, "R3");
    for (int i = 0; i < 14; i++) drive(1, 0, 0, 0, "R3");
    for (int i = 0; i < 12; i++) drive(i % 3 == 0, 0, 0, 0, "R2");
    drive(1, 1, 0, 3, "R10");
    for (int i = 0; i < 6; i++) drive(1, 0, 0, 0, "R11");

    // frequency mode
    reset_dut(2'b01);
    drive(0, 1, 2, 3, "R6");
    drive(0, 1, 1, 1, "R6");
    drive(0, 1, 3, 1, "R7");
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, "R7");
    for (int i = 0; i < 16; i++) drive(1, 0, 0, 0, "R6");
    drive(1, 1, 2, 0, "R4");
    for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, "R7");

    // dual-slope mode
    reset_dut(2'b10);
    drive(0, 1, 1, 3, "R8");
    drive(0, 1, 2, 2, "R8");
    drive(0, 1, 3, 0, "R8");
    drive(0, 1, 4, 3, "R8");
    drive(0, 1, 5, 7, "R8");
    for (int i = 0; i < 14; i++) drive(1, 0, 0, 0, "R9");
    drive(1, 1, 1, 6, "R4");
    for (int i = 0; i < 20; i++) drive(1, 0, 0, 0, "R8");
    for (int i = 0; i < 15; i++) drive(i % 2 == 1, 0, 0, 0, "R2");
    for (int i = 0; i < 12; i++) drive(1, 0, 0, 0, "R9");

    @(negedge clk);
    tick = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule